// File: doc/BRIEF.md
# FPGA Configuration Loader Sequencer

This block sits on the host side of an FPGA that is configured in slave-parallel mode. A `start` request makes it open an attempt by pulling the target's program-select line and its reset line low together. It holds reset low for a time derived from the clock frequency, then waits for the target's init line to rise. After that it pulls configuration bytes from an upstream valid/ready byte stream and writes each one to the target over an 8-bit bus with paired chip-select and write strobes. Before each write it waits for the target's ready input.

After the number of bytes given on `len` has been written, the sequencer waits a short settling time and samples the target's done line. If the done line is high, the load succeeded and `done` is raised. If it is low, the whole attempt starts again from the program/reset pulse, and the upstream source is expected to replay the bitstream from its first byte each time program-select falls. A length of zero fails at once and is retried in the same way.

A watchdog starts counting when a request is accepted. Retries do not restart it. If the load has not succeeded by the watchdog limit, the block pulls the active-low system reset output low for one reset-pulse time, sets `error` and returns to idle. The init, ready and done inputs are asynchronous and each passes through a two-flop synchronizer.

States: IDLE (waiting for start), PULSE (program/reset low), WAIT_INIT (waiting for init high), LEN_CHK (zero-length test and byte counter load), FETCH (stream handshake), WAIT_RDY (waiting for target ready), SETUP (bus driven, strobes high), STROBE (strobes low), HOLD (strobes high, bus held), CHECK (settle then sample done), FAULT (system reset driven).

Transitions:
- IDLE→PULSE on start.
- PULSE→WAIT_INIT when the pulse timer ends.
- WAIT_INIT→LEN_CHK when init is high.
- LEN_CHK→PULSE when the length is zero, otherwise LEN_CHK→FETCH.
- FETCH→WAIT_RDY when the stream presents a byte.
- WAIT_RDY→SETUP when ready is high.
- SETUP→STROBE.
- STROBE→HOLD when the strobe timer ends.
- HOLD→CHECK after the last byte, otherwise HOLD→FETCH.
- CHECK→IDLE if done is high, CHECK→PULSE if done is low.
- Any active state→FAULT on watchdog expiry.
- FAULT→IDLE when the reset timer ends.

Top module: `cfg_loader`

## Requirements
- R1: At the start of every attempt, `prog_n` and `fpga_rst_n` go low in the same clock cycle.
- R2: `fpga_rst_n` and `prog_n` stay low for exactly RST_CYC = CLK_HZ/1000000*RST_US cycles, then both return high.
- R3: No write strobe is asserted in an attempt until `init_n_in` has been seen high, after two-flop synchronization, following the release of `fpga_rst_n`.
- R4: While `rdy_in` is low, no write strobe is asserted. Writing resumes once `rdy_in` is high.
- R5: Each byte write drives `cs_n` and `wr_n` low together for exactly STROBE_CYC cycles, with the byte on `dbus`. Exactly `len` bytes are written per attempt, in stream order, and each byte is taken from one `s_valid`/`s_ready` handshake.
- R6: `dbus` holds its value for at least one cycle before the strobes fall and for at least one cycle after they rise.
- R7: After the last byte, and after SETTLE_CYC cycles, the synchronized `done_in` is sampled. If it is low, a new attempt starts with the R1 pulse. If it is high, the block returns to idle.
- R8: A `len` of zero writes no byte and causes an immediate retry.
- R9: The watchdog counts from the accepted start and is not restarted by retries. After WDOG_CYCLES cycles without success, `sys_rst_n` goes low for RST_CYC cycles, `error` goes to 1 and `busy` falls.
- R10: `busy` is 1 from the accepted start until the block returns to idle. `done` goes to 1 only after a successful done check. A new start clears both `done` and `error`, and the two are never 1 together.
- R11: `start` has no effect while `busy` is 1.
- R12: After reset, `prog_n`, `fpga_rst_n`, `cs_n`, `wr_n` and `sys_rst_n` are 1, and `busy`, `done`, `error` and `s_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a configuration load |
| len | input | LEN_W | Number of bytes in the bitstream, latched at start |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte present |
| s_ready | output | 1 | Stream byte accepted this cycle |
| init_n_in | input | 1 | Target init line, high when the target is ready for data (asynchronous) |
| rdy_in | input | 1 | Target byte-ready (asynchronous) |
| done_in | input | 1 | Target done/program line (asynchronous) |
| prog_n | output | 1 | Active-low program-select to target |
| fpga_rst_n | output | 1 | Active-low reset to target |
| cs_n | output | 1 | Active-low chip-select strobe |
| wr_n | output | 1 | Active-low write strobe |
| dbus | output | 8 | Configuration data bus |
| sys_rst_n | output | 1 | Active-low system reset on watchdog expiry |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load succeeded |
| error | output | 1 | Last load ended by the watchdog |

## Verification
The hardest case to reach from the ports is watchdog expiry in the middle of a retry loop. It has to show that repeated attempts do not push the timeout further out. The bench starts a load with a length of zero, so every attempt fails in LEN_CHK and loops back to PULSE. It then measures the number of cycles from start to the fall of `sys_rst_n` against the watchdog limit. A second route to the fault state is a model of the target that keeps init low forever, so the sequencer stays in WAIT_INIT until the watchdog fires. The retry path after a failed done check is also exercised. The target model holds `done_in` low until it has counted a second program pulse, and then checks that the replayed bytes match.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_INIT,
        ST_LEN_CHK,
        ST_FETCH,
        ST_WAIT_RDY,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_CHECK,
        ST_FAULT
    } cfg_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/cfg_watchdog.sv
module cfg_watchdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clear)                      cnt_q <= '0;
        else if (run && cnt_q != LAST)       cnt_q <= cnt_q + CW'(1);
    end

    assign expired = run && (cnt_q == LAST);

    // the counter never runs past its terminal value (R9)
    assert_wd_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST && run && !clear) |=> (cnt_q == LAST));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int RST_US      = 10,
    parameter int STROBE_CYC  = 2,
    parameter int SETTLE_CYC  = 3,
    parameter int WDOG_CYCLES = 150_000_000,
    parameter int LEN_W       = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic             init_n_in,
    input  logic             rdy_in,
    input  logic             done_in,
    output logic             prog_n,
    output logic             fpga_rst_n,
    output logic             cs_n,
    output logic             wr_n,
    output logic [7:0]       dbus,
    output logic             sys_rst_n,
    output logic             busy,
    output logic             done,
    output logic             error
);

    localparam int RST_CYC = CLK_HZ / 1_000_000 * RST_US;
    localparam int MAX_AB  = (RST_CYC > STROBE_CYC) ? RST_CYC : STROBE_CYC;
    localparam int TMR_MAX = (MAX_AB > SETTLE_CYC) ? MAX_AB : SETTLE_CYC;
    localparam int TW      = $clog2(TMR_MAX + 1);

    cfg_state_e state_q, state_d;

    logic             init_s, rdy_s, done_s;
    logic             tmr_load, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic             wd_clear, wd_run, wd_expired;
    logic             start_acc, check_pass;
    logic [LEN_W-1:0] len_q, rem_q;
    logic [7:0]       byte_q;
    logic             done_q, err_q;

    // ---------------- input synchronizers ----------------
    cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({init_n_in, rdy_in, done_in}),
        .q     ({init_s, rdy_s, done_s})
    );

    // ---------------- shared phase timer ----------------
    cfg_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    // ---------------- watchdog ----------------
    cfg_watchdog #(.LIMIT(WDOG_CYCLES)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wd_clear),
        .run     (wd_run),
        .expired (wd_expired)
    );

    assign start_acc  = (state_q == ST_IDLE) && start;
    assign check_pass = (state_q == ST_CHECK) && tmr_zero && done_s;
    assign wd_clear   = start_acc || check_pass;
    assign wd_run     = (state_q != ST_IDLE) && (state_q != ST_FAULT);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (wd_expired) begin
            state_d = ST_FAULT;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (start)      state_d = ST_PULSE;
                ST_PULSE:     if (tmr_zero)   state_d = ST_WAIT_INIT;
                ST_WAIT_INIT: if (init_s)     state_d = ST_LEN_CHK;
                ST_LEN_CHK:   state_d = (len_q == '0) ? ST_PULSE : ST_FETCH;
                ST_FETCH:     if (s_valid)    state_d = ST_WAIT_RDY;
                ST_WAIT_RDY:  if (rdy_s)      state_d = ST_SETUP;
                ST_SETUP:     state_d = ST_STROBE;
                ST_STROBE:    if (tmr_zero)   state_d = ST_HOLD;
                ST_HOLD:      state_d = (rem_q == LEN_W'(1)) ? ST_CHECK : ST_FETCH;
                ST_CHECK:     if (tmr_zero)   state_d = done_s ? ST_IDLE : ST_PULSE;
                ST_FAULT:     if (tmr_zero)   state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // phase timer is loaded on every state entry
    assign tmr_load = (state_d != state_q);

    always_comb begin
        case (state_d)
            ST_PULSE, ST_FAULT: tmr_val = TW'(RST_CYC - 1);
            ST_STROBE:          tmr_val = TW'(STROBE_CYC - 1);
            ST_CHECK:           tmr_val = TW'(SETTLE_CYC - 1);
            default:            tmr_val = '0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            rem_q  <= '0;
            byte_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start_acc) begin
                len_q  <= len;
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (state_q == ST_LEN_CHK)            rem_q  <= len_q;
            else if (state_q == ST_HOLD)          rem_q  <= rem_q - LEN_W'(1);
            if (state_q == ST_FETCH && s_valid)   byte_q <= s_data;
            if (check_pass && !wd_expired)        done_q <= 1'b1;
            if (wd_expired)                       err_q  <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        prog_n     = 1'b1;
        fpga_rst_n = 1'b1;
        cs_n       = 1'b1;
        wr_n       = 1'b1;
        sys_rst_n  = 1'b1;
        s_ready    = 1'b0;
        unique case (state_q)
            ST_PULSE: begin
                prog_n     = 1'b0;
                fpga_rst_n = 1'b0;
            end
            ST_FETCH:  s_ready   = 1'b1;
            ST_STROBE: begin
                cs_n = 1'b0;
                wr_n = 1'b0;
            end
            ST_FAULT:  sys_rst_n = 1'b0;
            default: ;
        endcase
    end

    assign dbus  = byte_q;
    assign busy  = (state_q != ST_IDLE);
    assign done  = done_q;
    assign error = err_q;

    // ---------------- assertions ----------------
    assert_pulse_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fpga_rst_n) |-> !prog_n);

    assert_no_write_before_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> init_s);

    assert_bus_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $stable(dbus));

    assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |=> $stable(dbus));

    assert_done_error_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_sysrst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> $past(wd_expired));

endmodule

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    localparam int RST_US     = 10;
    localparam int RST_CYC    = CLK_HZ / 1_000_000 * RST_US;
    localparam int STROBE_CYC = 2;
    localparam int SETTLE_CYC = 3;
    localparam int WDOG       = 3000;
    localparam int INIT_DLY   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] len_in = '0;
    logic [7:0]  s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic        init_n_in = 1'b1;
    logic        rdy_in = 1'b1;
    logic        done_in = 1'b1;
    logic        prog_n, fpga_rst_n, cs_n, wr_n, sys_rst_n, busy, done, error;
    logic [7:0]  dbus;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int pulses = 0;
    int writes_total = 0;
    int cap_n = 0;
    logic [7:0] cap [16];
    int idx = 0;
    bit took = 0;
    bit init_ok = 1;
    int init_cnt = 0;
    int rst_w = 0, wr_w = 0, sys_w = 0;
    int sys_fall_cyc = 0;
    bit sys_seen = 0;
    bit hold_pend = 0;
    logic [7:0] hold_val = '0;
    logic prev_frst = 1'b1, prev_wr = 1'b1, prev_sys = 1'b1;
    logic [7:0] prev_dbus = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_loader #(
        .CLK_HZ(CLK_HZ), .RST_US(RST_US), .STROBE_CYC(STROBE_CYC),
        .SETTLE_CYC(SETTLE_CYC), .WDOG_CYCLES(WDOG), .LEN_W(24)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len_in),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .init_n_in(init_n_in), .rdy_in(rdy_in), .done_in(done_in),
        .prog_n(prog_n), .fpga_rst_n(fpga_rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .dbus(dbus), .sys_rst_n(sys_rst_n), .busy(busy), .done(done), .error(error)
    );

    function automatic logic [7:0] pat(int i);
        logic [7:0] v;
        v = 8'(i * 37);
        return v ^ 8'hA5;
    endfunction

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // target model, stream source and strobe monitor (all at negedge)
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!fpga_rst_n && prev_frst) begin
                pulses++;
                chk("R1 prog_n low with fpga_rst_n", int'(prog_n), 0);
                idx = 0; took = 0; cap_n = 0; rst_w = 0;
            end
            if (!fpga_rst_n) rst_w++;
            if (fpga_rst_n && !prev_frst) begin
                chk("R2 reset pulse width", rst_w, RST_CYC);
                chk("R2 prog_n released with reset", int'(prog_n), 1);
                init_cnt = INIT_DLY;
            end
            if (!fpga_rst_n) init_n_in = 1'b0;
            else if (init_cnt > 0) begin
                init_cnt--;
                if (init_cnt == 0 && init_ok) init_n_in = 1'b1;
            end
            if (hold_pend) begin
                chk("R6 bus hold after strobe", int'(dbus), int'(hold_val));
                hold_pend = 0;
            end
            if (!wr_n && prev_wr) begin
                chk("R5 cs_n with wr_n", int'(cs_n), 0);
                chk("R3 init high before write", int'(init_n_in), 1);
                chk("R4 ready high before write", int'(rdy_in), 1);
                chk("R6 bus setup before strobe", int'(dbus), int'(prev_dbus));
                wr_w = 1;
                if (cap_n < 16) cap[cap_n] = dbus;
                cap_n++;
                writes_total++;
            end else if (!wr_n) begin
                wr_w++;
            end
            if (wr_n && !prev_wr) begin
                chk("R5 strobe width", wr_w, STROBE_CYC);
                hold_pend = 1;
                hold_val = dbus;
            end
            if (!sys_rst_n && prev_sys) begin
                sys_fall_cyc = cyc; sys_w = 0; sys_seen = 1;
            end
            if (!sys_rst_n) sys_w++;
            if (sys_rst_n && !prev_sys) chk("R9 system reset width", sys_w, RST_CYC);
        end
        if (took) idx++;
        took = s_ready && s_valid;
        s_valid = 1'b1;
        s_data = pat(idx);
        prev_frst = fpga_rst_n;
        prev_wr = wr_n;
        prev_sys = sys_rst_n;
        prev_dbus = dbus;
    end

    task automatic do_start(int l);
        @(negedge clk);
        len_in = 24'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(int maxc, string req);
        int n = 0;
        while (busy && n < maxc) begin
            @(negedge clk);
            n++;
        end
        chk({req, " returned to idle"}, int'(busy), 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 prog_n", int'(prog_n), 1);
        chk("R12 fpga_rst_n", int'(fpga_rst_n), 1);
        chk("R12 cs_n", int'(cs_n), 1);
        chk("R12 wr_n", int'(wr_n), 1);
        chk("R12 sys_rst_n", int'(sys_rst_n), 1);
        chk("R12 busy", int'(busy), 0);
        chk("R12 done", int'(done), 0);
        chk("R12 error", int'(error), 0);
        chk("R12 s_ready", int'(s_ready), 0);
    endtask

    task automatic t_basic();
        init_ok = 1; done_in = 1; rdy_in = 1;
        pulses = 0; writes_total = 0;
        do_start(5);
        repeat (20) @(negedge clk);
        chk("R10 busy during load", int'(busy), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle(1000, "R5");
        chk("R10 done after good load", int'(done), 1);
        chk("R10 error after good load", int'(error), 0);
        chk("R11 start ignored while busy", pulses, 1);
        chk("R5 byte count", cap_n, 5);
        for (int i = 0; i < 5; i++) chk("R5 byte order", int'(cap[i]), int'(pat(i)));
    endtask

    task automatic t_rdy_stall();
        pulses = 0; writes_total = 0;
        rdy_in = 1'b0;
        do_start(2);
        repeat (60) @(negedge clk);
        chk("R4 no write while not ready", writes_total, 0);
        chk("R4 still busy while stalled", int'(busy), 1);
        rdy_in = 1'b1;
        wait_idle(1000, "R4");
        chk("R4 writes after ready", writes_total, 2);
        chk("R4 done after stall", int'(done), 1);
    endtask

    task automatic t_retry();
        int n = 0;
        pulses = 0; writes_total = 0;
        done_in = 1'b0;
        do_start(3);
        while (pulses < 2 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R7 second attempt after failed check", pulses, 2);
        done_in = 1'b1;
        wait_idle(1000, "R7");
        chk("R7 done after retry", int'(done), 1);
        chk("R7 attempts", pulses, 2);
        chk("R7 total writes", writes_total, 6);
        chk("R7 replay count", cap_n, 3);
        for (int i = 0; i < 3; i++) chk("R7 replayed byte", int'(cap[i]), int'(pat(i)));
    endtask

    task automatic t_len_zero();
        int st;
        pulses = 0; writes_total = 0; sys_seen = 0;
        st = cyc;
        do_start(0);
        chk("R10 done cleared by start", int'(done), 0);
        wait_idle(WDOG + 200, "R8");
        chk("R8 no bytes for zero length", writes_total, 0);
        chk("R8 retried", int'(pulses > 2), 1);
        chk("R9 error set", int'(error), 1);
        chk("R9 done clear on fault", int'(done), 0);
        chk("R9 system reset seen", int'(sys_seen), 1);
        chk("R9 timeout not extended", int'((sys_fall_cyc - st) >= WDOG &&
                                             (sys_fall_cyc - st) <= WDOG + 8), 1);
    endtask

    task automatic t_init_stuck();
        pulses = 0; writes_total = 0; sys_seen = 0;
        init_ok = 0;
        do_start(2);
        chk("R10 error cleared by start", int'(error), 0);
        wait_idle(WDOG + 200, "R3");
        chk("R3 no write without init", writes_total, 0);
        chk("R9 error on stuck init", int'(error), 1);
        chk("R9 single attempt while waiting", pulses, 1);
        chk("R9 system reset on stuck init", int'(sys_seen), 1);
        init_ok = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_rdy_stall();
        t_retry();
        t_len_zero();
        t_init_stuck();
        t_basic();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule